// File: doc/BRIEF.md
# Ethernet receive destination-address filter

The filter watches the byte stream of an arriving Ethernet frame and decides, from the six destination-address bytes at its head, whether the frame is kept. Three checks are tried in a fixed order. An all-ones destination is the broadcast case. A destination with its group bit set, or any destination when individual-address hashing is on, looks up one bit of a 64-bit hash table. Every other destination is compared byte for byte with the station address.

A destination that fails its check is a miss. A miss is dropped unless promiscuous mode is on; in that mode the frame is kept and the miss flag travels with the decision so that later stages can mark it. A frame that ends before six bytes have arrived is a miss without any check. The decision is a single-cycle strobe with an accept bit and a miss bit. The mode bits and the address and hash registers are read in the strobe cycle and must be stable then.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid` stays low, and bytes that arrive without a preceding `byte_sof` produce no decision.
- R2: Each frame of six or more bytes gives exactly one `dec_valid` pulse, in the cycle after the clock edge that takes its sixth byte; later bytes of that frame give none. A byte with `byte_sof` always restarts collection as byte 0, abandoning any partial address.
- R3: If all 48 destination bits are one, miss equals `bcast_reject`; this check wins over the group-bit path.
- R4: If the first destination byte (the first byte received) has bit 0 set, the hash index is bits 31:26 of a CRC-32 register that starts at all ones and processes the six destination bytes least significant bit first with the reflected polynomial 0xEDB88320, with no final inversion. Indices 0 to 31 select bit (index) of `hash_lo`, indices 32 to 63 select bit (index − 32) of `hash_hi`. A set bit is a hit, a clear bit a miss.
- R5: With `ia_hash_en` set, a non-broadcast destination with bit 0 of its first byte clear uses the hash lookup of R4 in place of the address compare.
- R6: Otherwise the destination matches only when byte 0 equals `sta_addr_hi[15:8]`, byte 1 equals `sta_addr_hi[7:0]`, and bytes 2 to 5 equal `sta_addr_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` in that order.
- R7: At a decision, a hit gives accept 1 and miss 0; a miss gives accept 0 when `promisc_en` is clear and accept 1 with miss 1 when it is set.
- R8: A frame whose `byte_eof` byte is its first to fifth byte gives one decision in the cycle after that byte is taken, with miss 1 whatever its bytes hold and accept equal to `promisc_en`.
- R9: `dec_accept` and `dec_miss` are low whenever `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | A frame byte is present on `byte_data` |
| byte_data | input | 8 | Frame byte, destination byte 0 first |
| byte_sof | input | 1 | Marks the first byte of a frame (with `byte_vld`) |
| byte_eof | input | 1 | Marks the last byte of a frame (with `byte_vld`) |
| sta_addr_hi | input | 16 | Station address bytes 0 (15:8) and 1 (7:0) |
| sta_addr_lo | input | 32 | Station address bytes 2 (31:24) to 5 (7:0) |
| hash_lo | input | 32 | Hash table bits for indices 0 to 31 |
| hash_hi | input | 32 | Hash table bits for indices 32 to 63 |
| bcast_reject | input | 1 | Treat broadcast destinations as a miss |
| ia_hash_en | input | 1 | Hash individual (unicast) destinations too |
| promisc_en | input | 1 | Keep missed frames, flagged as misses |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame is kept |
| dec_miss | output | 1 | Destination failed its check |

## Verification
A decision is due exactly one cycle after the edge that takes the sixth byte, or after the edge that takes an early end-of-frame byte; no other cycle may carry `dec_valid`. The bench drives each byte on a falling edge and, on the following falling edge, before driving the next byte, looks at the strobe, so every pulse is tied to the index of the byte that caused it and the expected index is checked together with the count of pulses. A few idle cycles after each frame confirm no late pulse. Hash expectations come from a CRC written in the bench from R4, with the table bit placed in the right half, in the wrong half, or cleared among all ones.

// File: rtl/rx_afl_pkg.sv
// Shared sizes and the per-byte CRC step used for the hash index.
// Assumes frames carry the destination address in their first bytes.
package rx_afl_pkg;
    localparam int DA_BYTES = 6;
    localparam int BYTE_W   = 8;
    localparam int DA_W     = DA_BYTES * BYTE_W;
    localparam int CRC_W    = 32;
    localparam int HIDX_W   = 6;
    localparam int HREG_W   = 32;
    localparam int CNT_W    = $clog2(DA_BYTES + 1);
    localparam logic [CRC_W-1:0] CRC_POLY_REV = 32'hEDB88320;

    // Fold one byte into a reflected CRC-32, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] b);
        logic [CRC_W-1:0] r;
        r = c ^ {{(CRC_W-BYTE_W){1'b0}}, b};
        for (int k = 0; k < BYTE_W; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/rx_afl_collect.sv
// Gathers the destination bytes of a frame and runs the CRC over them.
// Raises done for one cycle after the last destination byte, or after an
// early end-of-frame (with short set). Idle until the next start marker.
module rx_afl_collect
    import rx_afl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_sof,
    input  logic              byte_eof,
    output logic [DA_W-1:0]   da_q,
    output logic [CRC_W-1:0]  crc_q,
    output logic              done_q,
    output logic              short_q
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pos;
    logic             take;
    logic             last_da;
    logic [CRC_W-1:0] crc_base;

    // Position of the incoming byte; a start marker forces position 0.
    always_comb begin
        pos      = byte_sof ? '0 : cnt_q;
        take     = byte_vld && (byte_sof || (cnt_q < CNT_W'(DA_BYTES)));
        last_da  = (pos == CNT_W'(DA_BYTES - 1));
        crc_base = byte_sof ? {CRC_W{1'b1}} : crc_q;
    end

    // Byte counter, address shift register, CRC and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= CNT_W'(DA_BYTES);
            da_q    <= '0;
            crc_q   <= {CRC_W{1'b1}};
            done_q  <= 1'b0;
            short_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            short_q <= 1'b0;
            if (take) begin
                da_q  <= {da_q[DA_W-BYTE_W-1:0], byte_data};
                crc_q <= crc_step(crc_base, byte_data);
                cnt_q <= pos + 1'b1;
                if (last_da) begin
                    done_q <= 1'b1;
                end else if (byte_eof) begin
                    done_q  <= 1'b1;
                    short_q <= 1'b1;
                    cnt_q   <= CNT_W'(DA_BYTES);
                end
            end
        end
    end

    // R2
    sixth_byte_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last_da) |=> (done_q && !short_q));

    // R2
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (cnt_q == CNT_W'(DA_BYTES)));

    // R8
    short_needs_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_q |-> $past(byte_eof && byte_vld));
endmodule

// File: rtl/rx_afl_match.sv
// Decides whether a collected destination misses: broadcast first, then
// hash lookup (group bit or individual hashing), then station compare.
// Purely combinational; inputs must be stable while done is high.
module rx_afl_match
    import rx_afl_pkg::*;
(
    input  logic [DA_W-1:0]   da,
    input  logic [CRC_W-1:0]  crc,
    input  logic              short_frame,
    input  logic [15:0]       sta_addr_hi,
    input  logic [31:0]       sta_addr_lo,
    input  logic [HREG_W-1:0] hash_lo,
    input  logic [HREG_W-1:0] hash_hi,
    input  logic              bcast_reject,
    input  logic              ia_hash_en,
    output logic              miss
);
    localparam int IDX_LO_W = $clog2(HREG_W);

    logic [DA_W-1:0]     sta;
    logic [DA_BYTES-1:0] byte_eq;
    logic [HIDX_W-1:0]   hidx;
    logic                hash_hit;
    logic                is_bcast;
    logic                group;

    assign sta = {sta_addr_hi, sta_addr_lo};

    // One comparator per destination byte, byte 0 in the top lane.
    for (genvar g = 0; g < DA_BYTES; g++) begin : g_cmp
        assign byte_eq[g] = (da[DA_W-1-g*BYTE_W -: BYTE_W] ==
                             sta[DA_W-1-g*BYTE_W -: BYTE_W]);
    end

    // Hash index from the top CRC bits; its MSB picks the register.
    always_comb begin
        hidx     = crc[CRC_W-1 -: HIDX_W];
        hash_hit = hidx[HIDX_W-1] ? hash_hi[hidx[IDX_LO_W-1:0]]
                                  : hash_lo[hidx[IDX_LO_W-1:0]];
        is_bcast = &da;
        group    = da[DA_W-BYTE_W];
    end

    // Ordered selection of the match path.
    always_comb begin
        if (short_frame)               miss = 1'b1;
        else if (is_bcast)             miss = bcast_reject;
        else if (group || ia_hash_en)  miss = !hash_hit;
        else                           miss = !(&byte_eq);
    end
endmodule

// File: rtl/rx_addr_filter.sv
// Receive destination-address filter top. Collects the first six bytes of
// a frame, classifies the destination and presents a one-cycle decision.
// Assumes mode, address and hash inputs are stable in the decision cycle.
module rx_addr_filter
    import rx_afl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_vld,
    input  logic [7:0]  byte_data,
    input  logic        byte_sof,
    input  logic        byte_eof,
    input  logic [15:0] sta_addr_hi,
    input  logic [31:0] sta_addr_lo,
    input  logic [31:0] hash_lo,
    input  logic [31:0] hash_hi,
    input  logic        bcast_reject,
    input  logic        ia_hash_en,
    input  logic        promisc_en,
    output logic        dec_valid,
    output logic        dec_accept,
    output logic        dec_miss
);
    logic [DA_W-1:0]  da_q;
    logic [CRC_W-1:0] crc_q;
    logic             done_q;
    logic             short_q;
    logic             miss;

    rx_afl_collect u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .byte_sof  (byte_sof),
        .byte_eof  (byte_eof),
        .da_q      (da_q),
        .crc_q     (crc_q),
        .done_q    (done_q),
        .short_q   (short_q)
    );

    rx_afl_match u_match (
        .da           (da_q),
        .crc          (crc_q),
        .short_frame  (short_q),
        .sta_addr_hi  (sta_addr_hi),
        .sta_addr_lo  (sta_addr_lo),
        .hash_lo      (hash_lo),
        .hash_hi      (hash_hi),
        .bcast_reject (bcast_reject),
        .ia_hash_en   (ia_hash_en),
        .miss         (miss)
    );

    // Decision outputs, qualified by the strobe.
    always_comb begin
        dec_valid  = done_q;
        dec_miss   = done_q && miss;
        dec_accept = done_q && (!miss || promisc_en);
    end

    // R7
    drop_when_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_miss && !promisc_en) |-> !dec_accept);

    // R7
    hit_accepted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_miss) |-> dec_accept);

    // R3
    bcast_follows_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !short_q && (&da_q)) |-> (dec_miss == bcast_reject));

    // R8
    short_is_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && short_q) |-> (dec_miss && (dec_accept == promisc_en)));

    // R9
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_accept && !dec_miss));
endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        byte_sof = 1'b0;
    logic        byte_eof = 1'b0;
    logic [15:0] sta_addr_hi = 16'h0211;
    logic [31:0] sta_addr_lo = 32'h22334455;
    logic [31:0] hash_lo = '0;
    logic [31:0] hash_hi = '0;
    logic        bcast_reject = 1'b0;
    logic        ia_hash_en = 1'b0;
    logic        promisc_en = 1'b0;
    logic        dec_valid, dec_accept, dec_miss;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rx_addr_filter uut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
        .byte_sof(byte_sof), .byte_eof(byte_eof), .sta_addr_hi(sta_addr_hi),
        .sta_addr_lo(sta_addr_lo), .hash_lo(hash_lo), .hash_hi(hash_hi),
        .bcast_reject(bcast_reject), .ia_hash_en(ia_hash_en),
        .promisc_en(promisc_en), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_miss(dec_miss)
    );

    typedef struct packed {
        logic [47:0] da;
        logic        bc;
        logic        ia;
        logic        pr;
        logic [1:0]  hm;   // 0 empty, 1 only bit, 2 all but bit, 3 wrong half
        logic        miss;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{48'hFFFFFFFFFFFF, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0},
        '{48'hFFFFFFFFFFFF, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1},
        '{48'hFFFFFFFFFFFF, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1},
        '{48'h01005E000001, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0},
        '{48'h01005E000001, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1},
        '{48'h021122334455, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0},
        '{48'h021122334454, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1},
        '{48'h021133224455, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1},
        '{48'h021122334455, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1},
        '{48'h0A1122334466, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0},
        '{48'h0A1122334466, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1},
        '{48'h331122334455, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1}
    };

    // Hash index per R4, bit at a time.
    function automatic logic [5:0] ref_idx(input logic [47:0] da);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic fb;
                fb = c[0] ^ da[47 - 8*i + j - 7];
                c  = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c[31:26];
    endfunction

    task automatic set_hash(input logic [47:0] da, input logic [1:0] hm);
        logic [5:0] ix;
        logic [63:0] t;
        ix = ref_idx(da);
        t  = 64'd0;
        case (hm)
            2'd1: t[ix] = 1'b1;
            2'd2: begin t = '1; t[ix] = 1'b0; end
            2'd3: t[ix ^ 6'd32] = 1'b1;
            default: t = 64'd0;
        endcase
        hash_lo = t[31:0];
        hash_hi = t[63:32];
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive n bytes (destination then filler); record strobes per byte index.
    task automatic send(input logic [47:0] da, input int n,
                        output int vcnt, output int vpos,
                        output logic acc, output logic mis);
        vcnt = 0; vpos = -1; acc = 1'b0; mis = 1'b0;
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            if (i > 0 && dec_valid) begin
                vcnt++; vpos = i - 1; acc = dec_accept; mis = dec_miss;
            end
            if (i < n) begin
                byte_vld  = 1'b1;
                byte_data = (i < 6) ? da[47 - 8*i -: 8] : 8'hA5;
                byte_sof  = (i == 0);
                byte_eof  = (i == n - 1);
            end else begin
                byte_vld = 1'b0; byte_sof = 1'b0; byte_eof = 1'b0;
            end
        end
        repeat (3) begin
            @(negedge clk);
            if (dec_valid) vcnt++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int vc, vp, seen;
        logic a, m;
        logic [47:0] da_l, da_h;
        bit got_l, got_h;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and stray bytes without a start marker
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (dec_valid || dec_accept || dec_miss) seen++;
            byte_vld = 1'b1; byte_data = 8'(i); byte_eof = (i == 7);
        end
        @(negedge clk);
        if (dec_valid) seen++;
        byte_vld = 1'b0; byte_eof = 1'b0;
        @(negedge clk);
        if (dec_valid) seen++;
        check("R1 no strobe after reset", seen, 0);

        // Vector table: R3 R4 R5 R6 R7, timing R2 and R9 for each
        for (int v = 0; v < NVEC; v++) begin
            bcast_reject = VEC[v].bc;
            ia_hash_en   = VEC[v].ia;
            promisc_en   = VEC[v].pr;
            set_hash(VEC[v].da, VEC[v].hm);
            send(VEC[v].da, 10, vc, vp, a, m);
            check($sformatf("R2 strobe count vec %0d", v), vc, 1);
            check($sformatf("R2 strobe position vec %0d", v), vp, 5);
            check($sformatf("R3/R4/R5/R6 miss vec %0d", v), int'(m), int'(VEC[v].miss));
            check($sformatf("R7 accept vec %0d", v), int'(a),
                  int'(!VEC[v].miss || VEC[v].pr));
        end
        bcast_reject = 1'b0; ia_hash_en = 1'b0; promisc_en = 1'b0;

        // R4: register halves, bit in the right and in the wrong register
        got_l = 0; got_h = 0; da_l = '0; da_h = '0;
        for (int b = 0; b < 256; b++) begin
            logic [47:0] d;
            d = {40'h01005E0000, 8'(b)};
            if (!got_l && ref_idx(d) < 6'd32) begin da_l = d; got_l = 1; end
            if (!got_h && ref_idx(d) >= 6'd32) begin da_h = d; got_h = 1; end
        end
        set_hash(da_l, 2'd1); send(da_l, 8, vc, vp, a, m);
        check("R4 low-half hit", int'(m), 0);
        set_hash(da_l, 2'd3); send(da_l, 8, vc, vp, a, m);
        check("R4 low-half bit in high register", int'(m), 1);
        set_hash(da_h, 2'd1); send(da_h, 8, vc, vp, a, m);
        check("R4 high-half hit", int'(m), 0);
        set_hash(da_h, 2'd3); send(da_h, 8, vc, vp, a, m);
        check("R4 high-half bit in low register", int'(m), 1);

        // R8: short frames
        set_hash(48'hFFFFFFFFFFFF, 2'd2);
        send(48'hFFFFFFFFFFFF, 3, vc, vp, a, m);
        check("R8 short count", vc, 1);
        check("R8 short position", vp, 2);
        check("R8 short miss", int'(m), 1);
        check("R8 short drop", int'(a), 0);
        promisc_en = 1'b1;
        send(48'h021122334455, 1, vc, vp, a, m);
        check("R8 one-byte position", vp, 0);
        check("R8 one-byte miss", int'(m), 1);
        check("R8 one-byte promisc accept", int'(a), 1);
        promisc_en = 1'b0;

        // R2: six-byte frame, end on the last address byte is not short
        send(48'h021122334455, 6, vc, vp, a, m);
        check("R2 six-byte count", vc, 1);
        check("R2 six-byte position", vp, 5);
        check("R6 six-byte match", int'(m), 0);

        // R2: a start marker mid-address restarts collection
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            byte_vld = 1'b1; byte_data = 8'hEE; byte_sof = (i == 0); byte_eof = 1'b0;
        end
        send(48'h021122334455, 9, vc, vp, a, m);
        check("R2 restart count", vc, 1);
        check("R2 restart position", vp, 5);
        check("R6 restart match", int'(m), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule